// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a logical address from a processor into a physical address by looking up a single-level page table held in memory. Each request carries a logical address and an access kind (read, write or instruction fetch). The upper part of the address selects a page-table entry. The entry's frame number replaces that upper part, and the low offset passes through unchanged. Pages are 2^PG_W bytes, with 4 KB by default. The outcome of a request is either a physical address or a fault. The fault code tells apart three cases: an out-of-range page, an invalid page and a forbidden access kind.

Two configuration registers set where the table starts and how many entries it holds. A fully associative translation cache sits in front of the table walk. By default it has 32 entries and is refilled in round-robin order. A hit answers without any memory traffic. A miss reads the entry through a read port with a valid/ready request and a response strobe. Software pulses a flush input after it moves the table base. The flush empties the cache, and it also blocks the fill from any walk that is still in flight.

Requests and responses use valid/ready handshakes, and only one request is in flight at a time. `req_ready` is high only while the unit is idle. Once `rsp_valid` rises, the response stays unchanged until the cycle in which `rsp_ready` is sampled high. The memory request likewise holds its address until `mem_req_ready` accepts it. The memory response has no back-pressure.

Top module: `page_xlate_unit`

## Requirements
- R1: A successful translation returns {frame number from entry bits [31:12], logical address bits [11:0]}.
- R2: On a cache miss the unit issues one memory read at address base + 4 × page number, and holds `mem_req_addr` stable until `mem_req_ready` is high.
- R3: A page number greater than or equal to the length register gives fault code 1 with physical address 0. No memory read is made, and the fault applies even when the page is cached.
- R4: An entry with bit 0 (valid) clear gives fault code 2 with physical address 0, and the entry is not cached, so a repeat access reads memory again.
- R5: Access code 0 (read) needs entry bit 1 (read-only) or bit 2 (read-write). Code 1 (write) needs bit 2. Code 2 (fetch) needs bit 3 (execute). Anything else gives fault code 3 with physical address 0.
- R6: A request whose page is cached completes with no memory read, and its permissions are checked against the cached bits.
- R7: Fills go into entries 0, 1, 2, … in turn and wrap after the last one. With 32 entries, the 33rd distinct fill evicts the first page filled and leaves the second page cached.
- R8: A `tlb_flush` pulse empties the cache and restarts the fill order. A flush while a walk is pending still returns that walk's result but does not cache it.
- R9: `req_ready` is low from the accept of a request until its response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response fields do not change.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req_valid` = 0, base = 0 and length = 0, so every request faults with code 1.
- R11: A write with `cfg_sel` = 0 loads the base register, and a write with `cfg_sel` = 1 loads the length register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table length |
| cfg_wdata | input | PA_W | Configuration write data |
| tlb_flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 permission |
| mem_req_valid | output | 1 | Page-table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W | Page-table entry read back |

## Verification
A corrupted cache tag or frame field shows up on the next hit to that page. The response arrives with no memory read, but its physical address does not match the table. A stale or skipped valid bit shows up as an extra or a missing memory read, which the bench counts per request. A wrong fill pointer only appears once the cache wraps, 33 distinct fills after a flush, through whichever page then misses or hits. Errors in the handshake state machine appear within a few cycles as a response that changes while it is held or as `req_ready` rising while a request is still busy.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_LEN  = 2'd1;
  localparam logic [1:0] FLT_INV  = 2'd2;
  localparam logic [1:0] FLT_PERM = 2'd3;

  // entry bit positions
  localparam int PTE_V  = 0;
  localparam int PTE_RO = 1;
  localparam int PTE_RW = 2;
  localparam int PTE_X  = 3;

  typedef struct packed {
    logic x;
    logic rw;
    logic ro;
  } perm_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_MREQ, S_MWAIT, S_RESP
  } walk_state_e;
endpackage

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base_q,
  output logic [W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (wr_en) begin
      if (sel) len_q  <= wdata;
      else     base_q <= wdata;
    end
  end
endmodule

// File: rtl/pxu_perm_check.sv
module pxu_perm_check
  import pxu_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       valid,
  input  perm_t      perm,
  output logic [1:0] fault
);
  logic allowed;

  always_comb begin
    unique case (acc)
      ACC_READ:  allowed = perm.ro | perm.rw;
      ACC_WRITE: allowed = perm.rw;
      ACC_FETCH: allowed = perm.x;
      default:   allowed = 1'b0;
    endcase
    if (!valid)        fault = FLT_INV;
    else if (!allowed) fault = FLT_PERM;
    else               fault = FLT_NONE;
  end
endmodule

// File: rtl/pxu_tlb.sv
module pxu_tlb
  import pxu_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  output perm_t            hit_perm,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  perm_t            fill_perm
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   tag_mem  [ENTRIES];
  logic [PFN_W-1:0]   pfn_mem  [ENTRIES];
  perm_t              perm_mem [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_mem[g] == lookup_vpn);
  end

  always_comb begin
    hit      = |match;
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_pfn  = hit_pfn | pfn_mem[i];
        hit_perm = hit_perm | perm_mem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_mem[ptr]  <= fill_vpn;
      pfn_mem[ptr]  <= fill_pfn;
      perm_mem[ptr] <= fill_perm;
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PG_W  = 12,
  parameter int PTE_W = 32,
  parameter int TLB_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  input  logic             tlb_flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int PFN_W = PA_W - PG_W;

  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PG_W-1:0]  off_q;
  logic [1:0]       acc_q;
  logic             drop_fill_q;
  logic [PA_W-1:0]  pte_addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic [1:0]       fault_q;

  logic [PA_W-1:0]  base_q, len_q;
  logic             hit;
  logic [PFN_W-1:0] hit_pfn;
  perm_t            hit_perm;
  perm_t            pte_perm;
  logic [PFN_W-1:0] pte_pfn;
  logic             chk_valid;
  perm_t            chk_perm;
  logic [1:0]       chk_fault;
  logic             len_fault;
  logic             fill_en;
  logic             unused_pte_bits;

  pxu_cfg_regs #(.W(PA_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel(cfg_sel),
    .wdata(cfg_wdata), .base_q(base_q), .len_q(len_q)
  );

  assign pte_pfn         = mem_rsp_data[PTE_W-1 -: PFN_W];
  assign pte_perm        = '{x: mem_rsp_data[PTE_X], rw: mem_rsp_data[PTE_RW],
                             ro: mem_rsp_data[PTE_RO]};
  assign unused_pte_bits = ^mem_rsp_data[PTE_W-PFN_W-1:PTE_X+1];

  assign fill_en = (state_q == S_MWAIT) && mem_rsp_valid && mem_rsp_data[PTE_V]
                   && !drop_fill_q && !tlb_flush;

  pxu_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) tlb_i (
    .clk(clk), .rst_n(rst_n), .flush(tlb_flush),
    .lookup_vpn(vpn_q), .hit(hit), .hit_pfn(hit_pfn), .hit_perm(hit_perm),
    .fill_en(fill_en), .fill_vpn(vpn_q), .fill_pfn(pte_pfn), .fill_perm(pte_perm)
  );

  // one checker serves both the cached path and the table-walk path
  assign chk_valid = (state_q == S_LOOK) ? 1'b1 : mem_rsp_data[PTE_V];
  assign chk_perm  = (state_q == S_LOOK) ? hit_perm : pte_perm;

  pxu_perm_check perm_i (
    .acc(acc_q), .valid(chk_valid), .perm(chk_perm), .fault(chk_fault)
  );

  assign len_fault = {{(PA_W-VPN_W){1'b0}}, vpn_q} >= len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      acc_q       <= '0;
      drop_fill_q <= 1'b0;
      pte_addr_q  <= '0;
      paddr_q     <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          vpn_q   <= req_vaddr[VA_W-1:PG_W];
          off_q   <= req_vaddr[PG_W-1:0];
          acc_q   <= req_acc;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          drop_fill_q <= 1'b0;
          if (len_fault) begin
            fault_q <= FLT_LEN;
            paddr_q <= '0;
            state_q <= S_RESP;
          end else if (hit) begin
            fault_q <= chk_fault;
            paddr_q <= (chk_fault == FLT_NONE) ? {hit_pfn, off_q} : '0;
            state_q <= S_RESP;
          end else begin
            pte_addr_q <= base_q + {{(PA_W-VPN_W-2){1'b0}}, vpn_q, 2'b00};
            state_q    <= S_MREQ;
          end
        end
        S_MREQ: begin
          if (tlb_flush) drop_fill_q <= 1'b1;
          if (mem_req_ready) state_q <= S_MWAIT;
        end
        S_MWAIT: begin
          if (tlb_flush) drop_fill_q <= 1'b1;
          if (mem_rsp_valid) begin
            fault_q <= chk_fault;
            paddr_q <= (chk_fault == FLT_NONE) ? {pte_pfn, off_q} : '0;
            state_q <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_addr  = pte_addr_q;
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk #(
  parameter int PA_W = 32,
  parameter int PG_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PG_W-1:0] req_off,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr
);
  logic [PG_W-1:0] off_cap;
  logic            mem_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_cap  <= '0;
      mem_seen <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_cap  <= req_off;
      mem_seen <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_seen <= 1'b1;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R3
  len_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd1 |-> !mem_seen);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd0 |-> rsp_paddr[PG_W-1:0] == off_cap);

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);
endmodule

bind page_xlate_unit pxu_chk #(.PA_W(PA_W), .PG_W(PG_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_off(req_vaddr[PG_W-1:0]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int TBL_LEN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tlb_flush = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int vectors = 0, fails = 0, mem_reads = 0, cycles = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] pt [64];
  logic [31:0] pend_addr = '0;
  int mcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tlb_flush(tlb_flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] rd_tbl(input logic [31:0] a);
    logic [31:0] d;
    d = a - BASE;
    if (d < 32'd256) return pt[d[7:2]];
    return 32'h0;
  endfunction

  // synchronous memory model: data two cycles after the accepted request
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rsp_valid <= (mcnt == 1);
    if (mcnt == 1) mem_rsp_data <= rd_tbl(pend_addr);
    if (mem_req_valid && mem_req_ready) begin
      pend_addr <= mem_req_addr;
      last_addr <= mem_req_addr;
      mem_reads <= mem_reads + 1;
      mcnt <= 2;
    end else if (mcnt > 0) begin
      mcnt <= mcnt - 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(input int vpn, input logic [11:0] off);
    return {20'h100 + 20'(vpn), off};
  endfunction

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input int hold,
                       output logic [31:0] pa, output logic [1:0] flt);
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    check("R9 req_ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; flt = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R9 held rsp_valid", 32'(rsp_valid), 32'd1);
      check("R9 held rsp_paddr", rsp_paddr, pa);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); tlb_flush = 1'b1;
    @(negedge clk); tlb_flush = 1'b0;
  endtask

  // expect a result and a given number of memory reads
  task automatic expect_x(input string req, input int vpn, input logic [11:0] off,
                          input logic [1:0] acc, input logic [1:0] eflt, input int ereads);
    logic [31:0] pa; logic [1:0] f; int r0;
    r0 = mem_reads;
    xlate({20'(vpn), off}, acc, 0, pa, f);
    check({req, " fault"}, 32'(f), 32'(eflt));
    check({req, " paddr"}, pa, (eflt == 2'd0) ? exp_pa(vpn, off) : 32'h0);
    check({req, " mem reads"}, 32'(mem_reads - r0), 32'(ereads));
  endtask

  task automatic t_reset();
    check("R10 req_ready", 32'(req_ready), 32'd1);
    check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 mem_req_valid", 32'(mem_req_valid), 32'd0);
    expect_x("R10 zero length", 0, 12'h010, 2'd0, 2'd1, 0);
  endtask

  task automatic t_miss_hit();
    expect_x("R1 miss", 2, 12'hABC, 2'd0, 2'd0, 1);
    check("R2 entry address", last_addr, BASE + 32'd8);
    expect_x("R6 hit", 2, 12'h123, 2'd1, 2'd0, 0);
    expect_x("R1 miss last page", 39, 12'hFFF, 2'd2, 2'd0, 1);
    check("R2 entry address last", last_addr, BASE + 32'd156);
  endtask

  task automatic t_length();
    expect_x("R3 page at length", 40, 12'h000, 2'd0, 2'd1, 0);
    expect_x("R3 far page", 1000, 12'h555, 2'd2, 2'd1, 0);
    cfg_write(1'b1, 32'd2);
    expect_x("R3 cached page beyond new length (R11)", 2, 12'h001, 2'd0, 2'd1, 0);
    cfg_write(1'b1, 32'(TBL_LEN));
  endtask

  task automatic t_invalid();
    expect_x("R4 invalid", 5, 12'h004, 2'd0, 2'd2, 1);
    expect_x("R4 invalid not cached", 5, 12'h008, 2'd0, 2'd2, 1);
  endtask

  task automatic t_perms();
    expect_x("R5 ro read", 6, 12'h100, 2'd0, 2'd0, 1);
    expect_x("R5 ro write", 6, 12'h100, 2'd1, 2'd3, 0);
    expect_x("R5 ro fetch", 6, 12'h100, 2'd2, 2'd3, 0);
    expect_x("R5 rw write", 7, 12'h200, 2'd1, 2'd0, 1);
    expect_x("R5 rw read", 7, 12'h200, 2'd0, 2'd0, 0);
    expect_x("R5 rw fetch", 7, 12'h200, 2'd2, 2'd3, 0);
    expect_x("R5 x read", 8, 12'h300, 2'd0, 2'd3, 1);
    expect_x("R5 x fetch", 8, 12'h300, 2'd2, 2'd0, 0);
    expect_x("R5 code 3", 8, 12'h300, 2'd3, 2'd3, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] pa; logic [1:0] f;
    xlate({20'd2, 12'h777}, 2'd0, 3, pa, f);
    check("R9 held result", pa, exp_pa(2, 12'h777));
    mem_req_ready = 1'b0;
    fork
      xlate({20'd10, 12'h010}, 2'd0, 0, pa, f);
      begin
        logic [31:0] a;
        @(negedge clk);
        while (!mem_req_valid) @(negedge clk);
        a = mem_req_addr;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check("R2 stall valid", 32'(mem_req_valid), 32'd1);
          check("R2 stall addr", mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
      end
    join
    check("R2 stalled walk result", pa, exp_pa(10, 12'h010));
  endtask

  task automatic t_flush();
    pulse_flush();
    expect_x("R8 after flush", 2, 12'h042, 2'd0, 2'd0, 1);
  endtask

  task automatic t_round_robin();
    int pg;
    pulse_flush();
    for (int i = 0; i < 33; i++) begin
      pg = (i < 5) ? i : i + 4;
      expect_x("R7 fill", pg, 12'h00C, 2'd0, 2'd0, 1);
    end
    expect_x("R7 second page still cached", 1, 12'h0AA, 2'd0, 2'd0, 0);
    expect_x("R7 first page evicted", 0, 12'h0BB, 2'd0, 2'd0, 1);
  endtask

  task automatic t_flush_pending();
    logic [31:0] pa; logic [1:0] f;
    pulse_flush();
    fork
      xlate({20'd3, 12'h333}, 2'd0, 0, pa, f);
      begin
        @(negedge clk);
        while (!mem_req_valid) @(negedge clk);
        @(negedge clk); tlb_flush = 1'b1;
        @(negedge clk); tlb_flush = 1'b0;
      end
    join
    check("R8 pending walk result", pa, exp_pa(3, 12'h333));
    expect_x("R8 pending fill dropped", 3, 12'h334, 2'd0, 2'd0, 1);
    expect_x("R8 refilled", 3, 12'h335, 2'd0, 2'd0, 0);
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pt[i] = {20'h100 + 20'(i), 8'h00, 4'hF};
    pt[5] = {20'h105, 8'h00, 4'hE};
    pt[6] = {20'h106, 8'h00, 4'h3};
    pt[7] = {20'h107, 8'h00, 4'h5};
    pt[8] = {20'h108, 8'h00, 4'h9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_write(1'b0, BASE);
    cfg_write(1'b1, 32'(TBL_LEN));
    t_miss_hit();
    t_length();
    t_invalid();
    t_perms();
    t_backpressure();
    t_flush();
    t_round_robin();
    t_flush_pending();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule